// File: doc/BRIEF.md
# I2C Controller Event Status and Interrupt Vector Unit

This block collects the events reported by an I2C master's bus engine and turns them into an interrupt. The engine signals five kinds of event with single-cycle pulses: arbitration lost, no-acknowledge, access ready, receive ready and transmit ready. Each pulse sets a sticky flag. The engine also supplies three live levels: bus busy, receive overrun and transmit underflow. These are shown in the status word but are never latched.

Software uses a 16-bit register port with three addresses: an enable mask, the status word and an encoded vector. The vector names the most urgent pending event that is enabled. An event can be acknowledged in two ways. Writing ones to the status word clears the flags at those positions. Reading the vector clears only the one event that the read reports. A single interrupt line is high while any enabled flag is set.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: Writing the enable register (reg_sel = 0) stores bits 4..0 as the mask. Reading it returns the mask in bits 4..0 and zeros in all other bits.
- R2: An event pulse on evt_pulse[i] sets flag i on the next clock edge. The flags are arbitration lost (bit 0), no-acknowledge (bit 1), access ready (bit 2), receive ready (bit 3) and transmit ready (bit 4). The status register (reg_sel = 1) shows them at those bit positions.
- R3: Writing the status register with a 1 at event bit i clears flag i on the next edge. A 0 at that bit leaves the flag unchanged.
- R4: Status bit 12 shows bus busy (lvl_in[2]), bit 11 shows receive overrun (lvl_in[1]) and bit 10 shows transmit underflow (lvl_in[0]). Each follows its input in the same cycle, and writing ones to these bits has no effect.
- R5: The vector register (reg_sel = 2) returns 0 when no enabled flag is pending. Otherwise it returns 1 for arbitration lost, 2 for no-acknowledge, 3 for access ready, 4 for receive ready or 5 for transmit ready. Flags whose enable bit is 0 are never reported.
- R6: When several enabled flags are pending, the vector reports the lowest code.
- R7: A read of the vector register clears only the flag it reports. A read that returns 0 clears nothing.
- R8: If an event pulse arrives in the same cycle as a clear of that same flag, by status write or by vector read, the flag stays set.
- R9: irq is high exactly when some flag and its enable bit are both 1.
- R10: A synchronous reset (rst high at a clock edge) clears all flags and the enable mask.
- R11: A flag sets whether or not it is enabled, and it stays visible in the status register while disabled.
- R12: Reads of reg_sel = 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 5 | Single-cycle event pulses, bit order as in R2 |
| lvl_in | input | 3 | Live levels: bit 2 busy, bit 1 overrun, bit 0 underflow |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; a vector read clears the reported event |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, valid in the same cycle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear and a new pulse on the same flag in the same cycle, while other flags are also pending. This matters most when the clear comes from a vector read, because the flag being cleared is then picked by the priority logic rather than named by software. Directed steps raise every event and drain them one at a time through vector reads, and they also land a pulse on exactly the flag being cleared. A long stretch of seeded random traffic follows. It mixes sparse pulses, random masks, status writes and vector reads, so collisions of this kind recur with many different sets of pending flags. A reference model in the bench checks every read value and the irq line each cycle.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_VECTOR = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // default event count and field placement
   localparam int EVT_COUNT_DEF = 5;
   localparam int LVL_COUNT_DEF = 3;
   localparam int LVL_LSB_DEF   = 10;

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);

   if (N < 1) begin : g_bad_n
      $error("evt_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;

      // a new pulse outranks any clear in the same cycle
      always_ff @(posedge clk) begin
         if (rst) flag_q <= 1'b0;
         else     flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
      end

      assign flag_o[i] = flag_q;

      p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
         set_i[i] |=> flag_o[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (rst)
         (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
      p_hold_r3: assert property (@(posedge clk) disable iff (rst)
         (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
   end

endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
   parameter int N      = 5,
   parameter int CODE_W = $clog2(N + 1)
) (
   input  logic [N-1:0]      req_i,
   output logic [N-1:0]      grant_o,
   output logic [CODE_W-1:0] code_o
);

   if ((1 << CODE_W) < N + 1) begin : g_bad_code
      $error("evt_prio_enc: CODE_W too narrow for N events");
   end

   // scan from the top so the lowest index is the last to win
   always_comb begin
      grant_o = '0;
      code_o  = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            grant_o    = '0;
            grant_o[k] = 1'b1;
            code_o     = CODE_W'(k + 1);
         end
      end
   end

   always_comb begin
      p_grant_onehot_r6: assert ($onehot0(grant_o));
   end

endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
   import i2c_evt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int N_EVT       = EVT_COUNT_DEF,
   parameter int N_LVL       = LVL_COUNT_DEF,
   parameter int LVL_LSB     = LVL_LSB_DEF,
   parameter bit RD_CLEAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic [N_LVL-1:0]  lvl_in,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);

   localparam int CODE_W = $clog2(N_EVT + 1);

   if (N_EVT > LVL_LSB) begin : g_bad_overlap
      $error("i2c_evt_irq_unit: event bits overlap level field");
   end
   if (LVL_LSB + N_LVL > DATA_W) begin : g_bad_lvl
      $error("i2c_evt_irq_unit: level field exceeds data width");
   end
   if (CODE_W > DATA_W) begin : g_bad_vec
      $error("i2c_evt_irq_unit: vector code exceeds data width");
   end

   reg_sel_e            sel;
   logic [N_EVT-1:0]    en_q;
   logic [N_EVT-1:0]    flags;
   logic [N_EVT-1:0]    pend;
   logic [N_EVT-1:0]    grant;
   logic [N_EVT-1:0]    wr_clr;
   logic [N_EVT-1:0]    rd_clr;
   logic [CODE_W-1:0]   vec_code;
   logic [DATA_W-1:0]   stat_word;
   logic [DATA_W-1:0]   vec_word;
   logic [DATA_W-1:0]   en_word;
   logic                unused_wbits;

   assign sel          = reg_sel_e'(reg_sel);
   assign unused_wbits = ^reg_wdata[DATA_W-1:N_EVT];

   // enable mask
   always_ff @(posedge clk) begin
      if (rst)                             en_q <= '0;
      else if (reg_wr && sel == SEL_ENABLE) en_q <= reg_wdata[N_EVT-1:0];
   end

   assign pend = flags & en_q;

   evt_prio_enc #(.N(N_EVT), .CODE_W(CODE_W)) u_prio (
      .req_i   (pend),
      .grant_o (grant),
      .code_o  (vec_code)
   );

   // write-one-to-clear from the status register
   assign wr_clr = (reg_wr && sel == SEL_STATUS) ? reg_wdata[N_EVT-1:0] : '0;

   // read-to-clear from the vector register, optional
   if (RD_CLEAR_EN) begin : g_rd_clear
      assign rd_clr = (reg_rd && sel == SEL_VECTOR) ? grant : '0;
   end else begin : g_no_rd_clear
      assign rd_clr = '0;
   end

   evt_flag_bank #(.N(N_EVT)) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set_i  (evt_pulse),
      .clr_i  (wr_clr | rd_clr),
      .flag_o (flags)
   );

   // read data assembly
   always_comb begin
      stat_word                    = '0;
      stat_word[N_EVT-1:0]         = flags;
      stat_word[LVL_LSB +: N_LVL]  = lvl_in;
      vec_word                     = '0;
      vec_word[CODE_W-1:0]         = vec_code;
      en_word                      = '0;
      en_word[N_EVT-1:0]           = en_q;
   end

   always_comb begin
      unique case (sel)
         SEL_ENABLE: reg_rdata = en_word;
         SEL_STATUS: reg_rdata = stat_word;
         SEL_VECTOR: reg_rdata = vec_word;
         default:    reg_rdata = '0;
      endcase
   end

   assign irq = |pend;

   p_rdclr_single_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rd_clr));
   p_irq_has_vector_r9: assert property (@(posedge clk) disable iff (rst)
      irq |-> (vec_code != '0));
   p_quiet_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
      (vec_code == '0) |-> !irq);
   p_reset_r10: assert property (@(posedge clk)
      rst |=> (flags == '0 && en_q == '0));

endmodule

// File: tb/tb_i2c_evt_irq_unit.sv
module tb_i2c_evt_irq_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  evt_pulse;
   logic [2:0]  lvl_in;
   logic [1:0]  reg_sel;
   logic        reg_wr;
   logic        reg_rd;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [4:0] m_flags;
   logic [4:0] m_en;

   always #10 clk = ~clk;

   i2c_evt_irq_unit dut (
      .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .lvl_in(lvl_in),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [2:0] m_vec();
      logic [2:0] v = 3'd0;
      for (int k = 4; k >= 0; k--)
         if (m_flags[k] && m_en[k]) v = 3'(k + 1);
      return v;
   endfunction

   function automatic logic [15:0] m_rdata(input logic [1:0] s);
      case (s)
         2'd0:    return {11'b0, m_en};
         2'd1:    return {3'b0, lvl_in, 5'b0, m_flags};
         2'd2:    return {13'b0, m_vec()};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [1:0] s, input logic w, input logic r,
                      input logic [15:0] wd, input logic [4:0] ev,
                      input logic [2:0] lv, input logic rs, input string tag);
      logic [4:0] clr;
      reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = wd;
      evt_pulse = ev; lvl_in = lv; rst = rs;
      #2;
      if (r) chk(tag, reg_rdata, m_rdata(s));
      chk("R9 irq", {15'b0, irq}, {15'b0, |(m_flags & m_en)});
      clr = (w && s == 2'd1) ? wd[4:0] : 5'd0;
      if (r && s == 2'd2 && m_vec() != 3'd0) clr[m_vec() - 1] = 1'b1;
      @(posedge clk);
      if (rs) begin
         m_flags = '0; m_en = '0;
      end else begin
         m_flags = ev | (m_flags & ~clr);
         if (w && s == 2'd0) m_en = wd[4:0];
      end
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] s, input logic [2:0] lv, input string tag);
      cyc(s, 1'b0, 1'b1, 16'h0, 5'h0, lv, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      m_flags = '0; m_en = '0;
      rst = 1'b1; evt_pulse = '0; lvl_in = '0; reg_sel = '0;
      reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
      @(negedge clk);
      cyc(2'd0, 1'b0, 1'b0, 16'h0, 5'h0, 3'h0, 1'b1, "R10");
      // R10 reset state
      rd(2'd0, 3'h0, "R10 enable after reset");
      rd(2'd1, 3'h0, "R10 status after reset");
      rd(2'd2, 3'h0, "R10 vector after reset");
      // R1 mask write, upper bits read zero
      cyc(2'd0, 1'b1, 1'b0, 16'hFFFF, 5'h0, 3'h0, 1'b0, "R1");
      rd(2'd0, 3'h0, "R1 enable readback");
      // R11 disabled event latched, R5 not reported
      cyc(2'd0, 1'b1, 1'b0, 16'h0000, 5'h08, 3'h0, 1'b0, "R11");
      rd(2'd1, 3'h0, "R11 disabled flag visible");
      rd(2'd2, 3'h0, "R5 disabled not in vector");
      // R5/R7 enable, read vector clears it
      cyc(2'd0, 1'b1, 1'b0, 16'h001F, 5'h0, 3'h0, 1'b0, "R5");
      rd(2'd2, 3'h0, "R5 receive ready code");
      rd(2'd1, 3'h0, "R7 cleared by vector read");
      // R6/R7 all pending drained in priority order
      cyc(2'd3, 1'b0, 1'b1, 16'h0, 5'h1F, 3'h0, 1'b0, "R12 unused select");
      for (int k = 0; k < 5; k++) begin
         rd(2'd2, 3'h0, "R6 priority order");
         rd(2'd1, 3'h0, "R7 only reported flag cleared");
      end
      rd(2'd2, 3'h0, "R7 empty vector");
      // R3 write zero no effect, write one clears
      cyc(2'd1, 1'b0, 1'b0, 16'h0, 5'h05, 3'h0, 1'b0, "R2");
      cyc(2'd1, 1'b1, 1'b0, 16'h0000, 5'h0, 3'h0, 1'b0, "R3");
      rd(2'd1, 3'h0, "R3 write zero keeps flags");
      cyc(2'd1, 1'b1, 1'b0, 16'h0001, 5'h0, 3'h0, 1'b0, "R3");
      rd(2'd1, 3'h0, "R3 write one clears");
      // R8 set wins over write clear and vector-read clear
      cyc(2'd1, 1'b1, 1'b0, 16'h0004, 5'h04, 3'h0, 1'b0, "R8");
      rd(2'd1, 3'h0, "R8 set beats write clear");
      cyc(2'd2, 1'b0, 1'b1, 16'h0, 5'h04, 3'h0, 1'b0, "R8 vector");
      rd(2'd1, 3'h0, "R8 set beats read clear");
      // R4 levels follow and ignore writes
      cyc(2'd1, 1'b1, 1'b0, 16'hFFFF, 5'h0, 3'h7, 1'b0, "R4");
      rd(2'd1, 3'h7, "R4 levels survive write");
      rd(2'd1, 3'h2, "R4 overrun only");
      rd(2'd1, 3'h4, "R4 busy only");
      // R10 reset with state present
      cyc(2'd0, 1'b0, 1'b0, 16'h0, 5'h1F, 3'h0, 1'b0, "R10");
      cyc(2'd0, 1'b1, 1'b0, 16'h001F, 5'h0, 3'h0, 1'b1, "R10");
      rd(2'd1, 3'h0, "R10 flags cleared");
      rd(2'd0, 3'h0, "R10 enable cleared");
      // random traffic
      seed = $urandom(32'h5EED_1234);
      for (int n = 0; n < 4000; n++) begin
         logic [1:0]  s  = 2'($urandom_range(0, 3));
         logic        w  = ($urandom_range(0, 9) < 2);
         logic        r  = ($urandom_range(0, 9) < 5);
         logic [15:0] wd = 16'($urandom);
         logic [4:0]  ev = 5'($urandom) & 5'($urandom);
         logic [2:0]  lv = 3'($urandom);
         logic        rs = ($urandom_range(0, 299) == 0);
         string tag;
         case (s)
            2'd0: tag = "R1 random enable";
            2'd1: tag = "R2 R3 R4 R8 random status";
            2'd2: tag = "R5 R6 R7 random vector";
            default: tag = "R12 random unused";
         endcase
         cyc(s, w, r, wd, ev, lv, rs, tag);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule